// File: doc/BRIEF.md
# Transmit Packet FIFO Front End

This block sits between a host register bus and a MAC transmitter. The host writes a frame into a data queue as 32-bit words. It then writes one command word that gives the frame's byte length and the position of the first valid byte inside the first word. Once the command is accepted, the block plays the frame out as a byte stream with valid/ready handshaking and marks the final byte. Only the bytes the command covers are sent: leading bytes before the offset and the padding after the last byte are dropped. Because of the offset, a host buffer that does not start on a word boundary can still be copied as whole words.

The host can see how full the data queue is through a word-count register and a level status register. Edge events are gathered in a source register that clears when read. These events are: frame sent, queue reached almost full, queue fell to almost empty, frame discarded, and write dropped because the queue was full. An enable mask selects which events drive the interrupt line. A control bit empties both queues and holds them empty until software clears the bit.

Register reads return data on the cycle after `bus_rd` is sampled. Register offsets used: 0x008 command, 0x00C data, 0x104 event source, 0x108 event enable, 0x110 level status, 0x120 almost-empty threshold, 0x124 control, 0x130 word count.

Top module: `txq_frontend`

## Requirements
- R1: After reset the word count reads 0, the threshold at 0x120 reads 384, the event source reads 0, `tx_valid` is low and `irq` is low.
- R2: A write to 0x00C appends one 32-bit word to the data queue (1024 words deep), and the count at 0x130 reports the number of stored words.
- R3: A write to 0x008 is a command: bits 15:0 hold the length in bytes and bits 17:16 hold the starting byte offset in the first word. No byte of a frame is presented before its command is accepted.
- R4: A frame uses floor((length + offset + 3) / 4) words. Its bytes come out least significant byte first, starting at the offset byte, and `tx_last` is high on exactly the final byte. The whole frame's words leave the queue.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: Event source bit 0 is set when the final byte of a frame is accepted.
- R7: A data write while the queue holds 1024 words is dropped and sets source bit 4. Status bit 2 reports the full state.
- R8: A command is discarded and sets source bit 3 in any of these cases: its word need exceeds the stored words not yet claimed by earlier commands, its length is 0, or the command queue is full. The unclaimed words are then removed from the data queue.
- R9: Status bit 0 is high while the count is at least 640. Source bit 1 is set when that condition becomes true.
- R10: Status bit 1 is high while the count is at most the threshold at 0x120. Source bit 2 is set when that condition becomes true.
- R11: Reading 0x104 returns the event bits and clears them, while keeping any event raised in the same cycle. `irq` is high while any source bit is set whose enable bit at 0x108 is set.
- R12: While control bit 4 at 0x124 is set, both queues are emptied, any frame in progress is abandoned, and data and command writes are ignored. This lasts until the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte present |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | Interrupt, OR of enabled event bits |

## Verification
The checker assumes the host issues at most one bus access per cycle and never asserts write and read together. The bench's bus tasks keep to that by pulsing a single strobe per call. The hold-while-stalled property assumes the transmitter may withdraw `tx_ready` at any cycle. The stall scenario exercises exactly that by toggling ready on a fixed pattern, and the other scenarios leave it high. The stall property is qualified by a pending flush write, because a flush is the only legal way for a presented byte to disappear before it is accepted.

// File: rtl/txq_frontend.sv
module txq_frontend #(
  parameter int DEPTH     = 1024,
  parameter int AF_MARGIN = 384,
  parameter int AE_RESET  = 384,
  parameter int CMD_DEPTH = 8,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          irq
);
  localparam int PW       = $clog2(DEPTH);
  localparam int CW       = PW + 1;
  localparam int QW       = $clog2(CMD_DEPTH);
  localparam int AF_LEVEL = DEPTH - AF_MARGIN;

  localparam logic [AW-1:0] A_CMD  = AW'('h008);
  localparam logic [AW-1:0] A_DATA = AW'('h00C);
  localparam logic [AW-1:0] A_SRC  = AW'('h104);
  localparam logic [AW-1:0] A_IEN  = AW'('h108);
  localparam logic [AW-1:0] A_STAT = AW'('h110);
  localparam logic [AW-1:0] A_THR  = AW'('h120);
  localparam logic [AW-1:0] A_CTRL = AW'('h124);
  localparam logic [AW-1:0] A_WCNT = AW'('h130);

  logic [31:0]   mem [DEPTH];
  logic [17:0]   cq  [CMD_DEPTH];
  logic [CW-1:0] wp, rp, resv, thr_q;
  logic [QW:0]   cwp, crp;
  logic          busy;
  logic [15:0]   left;
  logic [1:0]    idx;
  logic [4:0]    src_q, ien_q;
  logic          flush_q, af_q, ae_q;

  wire [CW-1:0] count  = wp - rp;
  wire          full   = count == CW'(DEPTH);
  wire [QW:0]   qcount = cwp - crp;

  wire wr_data = bus_wr && bus_addr == A_DATA && !flush_q;
  wire wr_cmd  = bus_wr && bus_addr == A_CMD && !flush_q;
  wire push    = wr_data && !full;
  wire drop    = wr_data && full;

  wire [17:0]   need    = (18'(bus_wdata[15:0]) + 18'(bus_wdata[17:16]) + 18'd3) >> 2;
  wire [CW-1:0] unres   = count - resv;
  wire          cmd_ok  = wr_cmd && bus_wdata[15:0] != 16'd0 &&
                          qcount != (QW+1)'(CMD_DEPTH) && need <= 18'(unres);
  wire          discard = wr_cmd && !cmd_ok;

  wire [17:0] head = cq[crp[QW-1:0]];
  wire [31:0] word = mem[rp[PW-1:0]];

  assign tx_valid = busy && !flush_q;
  assign tx_data  = word[{idx, 3'b000} +: 8];
  assign tx_last  = left == 16'd1;

  wire fire = tx_valid && tx_ready;
  wire fin  = fire && tx_last;
  wire pop  = fire && (idx == 2'd3 || tx_last);

  wire [CW-1:0] rp_n   = rp + CW'(pop);
  wire [CW-1:0] resv_n = resv + (cmd_ok ? need[CW-1:0] : '0) - CW'(pop);

  wire       af_lvl = count >= CW'(AF_LEVEL);
  wire       ae_lvl = count <= thr_q;
  wire [4:0] ev     = {drop, discard, ae_lvl & ~ae_q, af_lvl & ~af_q, fin};

  assign irq = |(src_q & ien_q);

  always_ff @(posedge clk) begin
    if (push)   mem[wp[PW-1:0]] <= bus_wdata;
    if (cmd_ok) cq[cwp[QW-1:0]] <= bus_wdata[17:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; resv <= '0;
      cwp <= '0; crp <= '0;
      busy <= 1'b0; left <= '0; idx <= '0;
      src_q <= '0; ien_q <= '0;
      thr_q <= CW'(AE_RESET);
      flush_q <= 1'b0; af_q <= 1'b0; ae_q <= 1'b1;
    end else begin
      af_q  <= af_lvl;
      ae_q  <= ae_lvl;
      src_q <= ((bus_rd && bus_addr == A_SRC) ? 5'd0 : src_q) | ev;
      if (bus_wr) begin
        case (bus_addr)
          A_IEN:   ien_q   <= bus_wdata[4:0];
          A_THR:   thr_q   <= bus_wdata[CW-1:0];
          A_CTRL:  flush_q <= bus_wdata[4];
          default: ;
        endcase
      end
      if (flush_q) begin
        wp <= '0; rp <= '0; resv <= '0;
        cwp <= '0; crp <= '0;
        busy <= 1'b0; left <= '0; idx <= '0;
      end else begin
        rp   <= rp_n;
        resv <= resv_n;
        wp   <= discard ? rp_n + resv_n : wp + CW'(push);
        if (cmd_ok) cwp <= cwp + 1'b1;
        if (!busy && qcount != '0) begin
          busy <= 1'b1;
          left <= head[15:0];
          idx  <= head[17:16];
        end else if (fire) begin
          left <= left - 16'd1;
          idx  <= idx + 2'd1;
          if (fin) begin
            busy <= 1'b0;
            crp  <= crp + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_SRC:   bus_rdata <= {27'd0, src_q};
        A_IEN:   bus_rdata <= {27'd0, ien_q};
        A_STAT:  bus_rdata <= {28'd0, busy, full, ae_lvl, af_lvl};
        A_THR:   bus_rdata <= 32'(thr_q);
        A_CTRL:  bus_rdata <= {27'd0, flush_q, 4'd0};
        A_WCNT:  bus_rdata <= 32'(count);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txq_frontend_chk.sv
module txq_frontend_chk #(
  parameter int DEPTH = 1024,
  parameter int AW    = 12,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          wdata_flush,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          flush,
  input logic [CW-1:0] wcount,
  input logic          full_flag
);
  wire flush_wr = bus_wr && bus_addr == AW'('h124) && wdata_flush;
  wire data_wr  = bus_wr && bus_addr == AW'('h00C);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= CW'(DEPTH)); // R2

  AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> wcount != '0); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !flush_wr |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R5

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !flush && wcount == CW'(DEPTH) |=> full_flag); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> wcount == '0 && !tx_valid); // R12
endmodule

bind txq_frontend txq_frontend_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_flush(bus_wdata[4]), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .flush(flush_q),
  .wcount(count), .full_flag(src_q[4])
);

// File: tb/txq_frontend_test.sv
module txq_frontend_test;
  localparam logic [11:0] A_CMD  = 12'h008;
  localparam logic [11:0] A_DATA = 12'h00C;
  localparam logic [11:0] A_SRC  = 12'h104;
  localparam logic [11:0] A_IEN  = 12'h108;
  localparam logic [11:0] A_STAT = 12'h110;
  localparam logic [11:0] A_THR  = 12'h120;
  localparam logic [11:0] A_CTRL = 12'h124;
  localparam logic [11:0] A_WCNT = 12'h130;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic tx_valid, tx_last, irq;
  logic tx_ready = 1'b1;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int cyc = 0;
  logic [7:0] cap_d [64];
  logic       cap_l [64];
  int cap_n = 0;

  always #4 clk = ~clk;

  txq_frontend uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .irq(irq)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
      cap_d[cap_n] = tx_data;
      cap_l[cap_n] = tx_last;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mkword(input int b);
    return {8'(b + 3), 8'(b + 2), 8'(b + 1), 8'(b)};
  endfunction

  task automatic wait_bytes(input int n);
    for (int k = 0; k < 4000 && cap_n < n; k++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(input string req, input int base, input int off, input int len);
    logic [31:0] v;
    int nw = (len + off + 3) / 4;
    cap_n = 0;
    for (int i = 0; i < nw; i++) bus_write(A_DATA, mkword(base + 4 * i));
    bus_write(A_CMD, (off << 16) | len);
    wait_bytes(len);
    chk(cap_n == len, req, "byte count", cap_n, len);
    for (int j = 0; j < len && j < 64; j++) begin
      chk(cap_d[j] == 8'(base + off + j), req, "byte value", cap_d[j], 8'(base + off + j));
      chk(cap_l[j] == (j == len - 1), req, "last marker", cap_l[j], j == len - 1);
    end
    bus_read(A_WCNT, v);
    chk(v == 0, req, "queue drained", v, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(tx_valid == 0, "R1", "valid after reset", tx_valid, 0);
    chk(irq == 0, "R1", "irq after reset", irq, 0);
    bus_read(A_WCNT, v); chk(v == 0, "R1", "count", v, 0);
    bus_read(A_THR, v);  chk(v == 384, "R1", "threshold", v, 384);
    bus_read(A_SRC, v);  chk(v == 0, "R1", "source", v, 0);
  endtask

  task automatic t_hold_until_cmd();
    logic [31:0] v;
    cap_n = 0;
    for (int i = 0; i < 3; i++) bus_write(A_DATA, mkword(16 + 4 * i));
    repeat (20) @(negedge clk);
    chk(cap_n == 0 && tx_valid == 0, "R3", "no output before command", cap_n, 0);
    bus_read(A_WCNT, v); chk(v == 3, "R2", "count after three writes", v, 3);
    bus_write(A_CMD, 32'd12);
    wait_bytes(12);
    chk(cap_n == 12, "R3", "bytes after command", cap_n, 12);
    for (int j = 0; j < 12; j++)
      chk(cap_d[j] == 8'(16 + j), "R4", "lsb first order", cap_d[j], 8'(16 + j));
    bus_read(A_WCNT, v); chk(v == 0, "R2", "count after frame", v, 0);
  endtask

  task automatic t_offsets();
    run_frame("R4", 32, 0, 8);
    run_frame("R4", 64, 3, 5);
    run_frame("R4", 96, 1, 2);
    run_frame("R4", 128, 2, 9);
  endtask

  task automatic t_stall();
    stall_mode = 1;
    run_frame("R5", 160, 1, 11);
    stall_mode = 0;
  endtask

  task automatic t_sent_irq();
    logic [31:0] v;
    bus_read(A_SRC, v);
    bus_write(A_IEN, 32'h1);
    run_frame("R6", 200, 0, 4);
    chk(irq == 1, "R11", "irq after sent", irq, 1);
    bus_read(A_SRC, v); chk(v[0] == 1, "R6", "sent bit", v[0], 1);
    @(negedge clk);
    chk(irq == 0, "R11", "irq after read", irq, 0);
    bus_read(A_SRC, v); chk(v == 0, "R11", "source cleared", v, 0);
    bus_write(A_IEN, 32'h0);
  endtask

  task automatic t_discard();
    logic [31:0] v;
    bus_read(A_SRC, v);
    cap_n = 0;
    bus_write(A_DATA, mkword(7));
    bus_write(A_CMD, 32'd8);
    repeat (10) @(negedge clk);
    chk(cap_n == 0, "R8", "no output of short frame", cap_n, 0);
    bus_read(A_SRC, v); chk(v[3] == 1, "R8", "discard bit", v[3], 1);
    bus_read(A_WCNT, v); chk(v == 0, "R8", "unclaimed removed", v, 0);
    bus_write(A_CMD, 32'd0);
    bus_read(A_SRC, v); chk(v[3] == 1, "R8", "zero length discarded", v[3], 1);
    run_frame("R8", 40, 2, 6);
  endtask

  task automatic t_full_flush();
    logic [31:0] v;
    bus_read(A_SRC, v);
    for (int i = 0; i < 1024; i++) bus_write(A_DATA, 32'(i));
    bus_read(A_WCNT, v); chk(v == 1024, "R7", "count at capacity", v, 1024);
    bus_read(A_STAT, v);
    chk(v[2] == 1, "R7", "full status", v[2], 1);
    chk(v[0] == 1, "R9", "almost full status", v[0], 1);
    bus_write(A_DATA, 32'hDEAD);
    bus_read(A_WCNT, v); chk(v == 1024, "R7", "write dropped", v, 1024);
    bus_read(A_SRC, v);
    chk(v[4] == 1, "R7", "full event", v[4], 1);
    chk(v[1] == 1, "R9", "almost full event", v[1], 1);
    bus_write(A_CTRL, 32'h10);
    bus_read(A_WCNT, v); chk(v == 0, "R12", "flushed", v, 0);
    bus_write(A_DATA, 32'h1);
    bus_read(A_WCNT, v); chk(v == 0, "R12", "write ignored in flush", v, 0);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_WCNT, v); chk(v == 0, "R12", "empty after release", v, 0);
    run_frame("R12", 70, 0, 7);
  endtask

  task automatic t_almost_empty();
    logic [31:0] v;
    bus_write(A_THR, 32'd2);
    bus_read(A_THR, v); chk(v == 2, "R10", "threshold readback", v, 2);
    bus_read(A_SRC, v);
    cap_n = 0;
    for (int i = 0; i < 4; i++) bus_write(A_DATA, mkword(4 * i));
    bus_read(A_SRC, v); chk(v[2] == 0, "R10", "no event while filling", v[2], 0);
    bus_read(A_STAT, v); chk(v[1] == 0, "R10", "above threshold", v[1], 0);
    bus_write(A_CMD, 32'd16);
    wait_bytes(16);
    bus_read(A_SRC, v);
    chk(v[2] == 1, "R10", "almost empty event", v[2], 1);
    chk(v[0] == 1, "R6", "sent with almost empty", v[0], 1);
    bus_write(A_THR, 32'd384);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_until_cmd();
    t_offsets();
    t_stall();
    t_sent_irq();
    t_discard();
    t_full_flush();
    t_almost_empty();
    summary();
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule